// File: doc/BRIEF.md
# Trap entry and privileged status unit

This block keeps a processor's privileged control state and carries out trap entry. It holds an eight-bit status word with five meaningful bits, an exception base address, a saved exception PC, a captured faulting address and a count of retired instructions. Software may rewrite the status word and the exception base. The block reports the active general-register width, which the status bits select.

A trap request is a one-cycle strobe that carries a cause number, the PC of the trapping instruction and a faulting address. If traps are enabled and the cause is legal, the block saves the PC and the address and switches to supervisor mode, remembering the previous mode. One cycle later it presents a redirect target together with a one-cycle valid strobe. If traps are disabled or the cause is out of range, the block instead enters an error mode that holds until reset. The trap, status-write and retire inputs are plain strobes with no back-pressure. The block is always ready, and the redirect output cannot be stalled, so the fetch stage must take it in the cycle it is valid.

Top module: `trap_status_unit`

## Requirements
- R1: One cycle after a serviced trap request, `redirect_valid` is high for exactly one cycle, and `redirect_pc` equals the exception base plus the cause number times 128. The exception base resets to zero and is loaded through `ebase_wr_en`/`ebase_wr_data`.
- R2: Status bit positions are S=bit0 (supervisor), PS=bit1 (previous supervisor), ET=bit2 (traps enabled), UX=bit3 (user 64-bit) and KX=bit4 (kernel 64-bit). On a serviced trap, ET is cleared, S is set and PS takes the value S had before the trap. UX and KX keep their values.
- R3: On a serviced trap, `epc` captures `trap_pc` and `badvaddr` captures `trap_badaddr`.
- R4: A trap request while ET is 0 is not serviced. It gives no redirect, leaves `status`, `epc` and `badvaddr` unchanged, and sets `error_mode`. `error_mode` stays high until reset, and every later trap request is ignored.
- R5: A trap request whose cause is at or above NUM_TRAPS (default 20) sets `error_mode` in the same way as R4, with no redirect.
- R6: On every status update, bits 7..5 are forced to 0. With HAS_64=1 (the default), KX is forced to 1. With HAS_64=0, both KX and UX are forced to 0.
- R7: `active_width` is 64 when the selected bit is set and 32 otherwise. The selected bit is KX when S=1 and UX when S=0.
- R8: After reset, `status` is 0x11 (S and the forced KX), and `epc`, `badvaddr`, `ebase`, `redirect_pc`, `retired` and `error_mode` are 0.
- R9: `retired` increments by one for each `retire` pulse, except when `trap_req` is high in the same cycle.
- R10: When a trap request and a status write occur in the same cycle, the trap result is loaded and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_data | input | 8 | Status write value |
| ebase_wr_en | input | 1 | Exception-base write strobe |
| ebase_wr_data | input | ADDR_W | Exception-base write value |
| trap_req | input | 1 | Trap request strobe |
| trap_cause | input | CAUSE_W | Trap cause number |
| trap_pc | input | ADDR_W | PC of trapping instruction |
| trap_badaddr | input | ADDR_W | Faulting address |
| retire | input | 1 | Instruction-completed strobe |
| status | output | 8 | Status word |
| active_width | output | 7 | Active register width, 32 or 64 |
| ebase | output | ADDR_W | Exception base |
| epc | output | ADDR_W | Saved exception PC |
| badvaddr | output | ADDR_W | Saved faulting address |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | ADDR_W | Trap vector target |
| error_mode | output | 1 | Sticky fatal-error flag |
| retired | output | CNT_W | Retired-instruction count |

## Verification
The hardest case to reach is a retire pulse that coincides with a serviced trap while a status write is also pending. It needs ET set beforehand and three strobes aligned on one edge. The bench first writes a status word with ET set. In the following cycle it raises the trap, the retire pulse and a conflicting status write together, and then checks the count, the status word and the redirect. Error mode is reached twice, once by an illegal cause and once by a trap with ET clear directly after reset. A second reset between the two runs is the only way to clear the sticky flag.

// File: rtl/trap_status_pkg.sv
package trap_status_pkg;
  localparam int SR_W   = 8;
  localparam int BIT_S  = 0;
  localparam int BIT_PS = 1;
  localparam int BIT_ET = 2;
  localparam int BIT_UX = 3;
  localparam int BIT_KX = 4;
  localparam logic [SR_W-1:0] SR_LIVE_MASK = 8'h1F;

  typedef logic [SR_W-1:0] sr_word_t;

  function automatic sr_word_t sr_clean(input sr_word_t raw, input bit has64);
    sr_word_t v;
    v = raw & SR_LIVE_MASK;
    if (has64) v[BIT_KX] = 1'b1;
    else begin
      v[BIT_KX] = 1'b0;
      v[BIT_UX] = 1'b0;
    end
    return v;
  endfunction
endpackage

// File: rtl/sr_bank.sv
module sr_bank
  import trap_status_pkg::*;
#(
  parameter bit HAS_64 = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trap_take,
  input  logic     wr_en,
  input  sr_word_t wr_data,
  output sr_word_t sr_q,
  output logic     wide
);
  sr_word_t raw_d;

  always_comb begin
    raw_d = sr_q;
    if (trap_take) begin
      raw_d[BIT_PS] = sr_q[BIT_S];
      raw_d[BIT_S]  = 1'b1;
      raw_d[BIT_ET] = 1'b0;
    end else if (wr_en) begin
      raw_d = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= sr_clean(sr_word_t'(1 << BIT_S), HAS_64);
    else        sr_q <= sr_clean(raw_d, HAS_64);
  end

  assign wide = sr_q[BIT_S] ? sr_q[BIT_KX] : sr_q[BIT_UX];
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
  parameter int ADDR_W    = 32,
  parameter int CAUSE_W   = 5,
  parameter int NUM_TRAPS = 20,
  parameter int VEC_SHIFT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [ADDR_W-1:0]  pc_in,
  input  logic [ADDR_W-1:0]  bad_in,
  input  logic               et_bit,
  input  logic [ADDR_W-1:0]  base,
  output logic               trap_take,
  output logic               redirect_valid,
  output logic [ADDR_W-1:0]  redirect_pc,
  output logic [ADDR_W-1:0]  epc_q,
  output logic [ADDR_W-1:0]  bad_q,
  output logic               err_q
);
  localparam int CAUSE_SPAN = 1 << CAUSE_W;
  localparam bit CAUSE_FULL = (NUM_TRAPS >= CAUSE_SPAN);

  logic cause_ok;
  logic fault;
  logic [ADDR_W-1:0] vector;

  generate
    if (CAUSE_FULL) begin : g_all_legal
      assign cause_ok = 1'b1;
    end else begin : g_range
      assign cause_ok = (32'(cause) < 32'(NUM_TRAPS));
    end
  endgenerate

  assign trap_take = trap_req && !err_q && et_bit && cause_ok;
  assign fault     = trap_req && !err_q && (!et_bit || !cause_ok);
  assign vector    = base + (ADDR_W'(cause) << VEC_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      epc_q          <= '0;
      bad_q          <= '0;
      err_q          <= 1'b0;
    end else begin
      redirect_valid <= trap_take;
      if (trap_take) begin
        redirect_pc <= vector;
        epc_q       <= pc_in;
        bad_q       <= bad_in;
      end
      if (fault) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/retire_counter.sv
module retire_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + 1'b1;
  end
endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_status_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CAUSE_W   = 5,
  parameter int NUM_TRAPS = 20,
  parameter int CNT_W     = 32,
  parameter bit HAS_64    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sr_wr_en,
  input  logic [7:0]         sr_wr_data,
  input  logic               ebase_wr_en,
  input  logic [ADDR_W-1:0]  ebase_wr_data,
  input  logic               trap_req,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [ADDR_W-1:0]  trap_pc,
  input  logic [ADDR_W-1:0]  trap_badaddr,
  input  logic               retire,
  output logic [7:0]         status,
  output logic [6:0]         active_width,
  output logic [ADDR_W-1:0]  ebase,
  output logic [ADDR_W-1:0]  epc,
  output logic [ADDR_W-1:0]  badvaddr,
  output logic               redirect_valid,
  output logic [ADDR_W-1:0]  redirect_pc,
  output logic               error_mode,
  output logic [CNT_W-1:0]   retired
);
  localparam int VEC_SHIFT = 7;
  localparam logic [6:0] W_NARROW = 7'd32;
  localparam logic [6:0] W_WIDE   = 7'd64;

  logic     take;
  logic     wide;
  sr_word_t sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           ebase <= '0;
    else if (ebase_wr_en) ebase <= ebase_wr_data;
  end

  sr_bank #(.HAS_64(HAS_64)) u_sr (
    .clk(clk), .rst_n(rst_n), .trap_take(take),
    .wr_en(sr_wr_en), .wr_data(sr_wr_data),
    .sr_q(sr_q), .wide(wide)
  );

  trap_sequencer #(
    .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W),
    .NUM_TRAPS(NUM_TRAPS), .VEC_SHIFT(VEC_SHIFT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .cause(trap_cause),
    .pc_in(trap_pc), .bad_in(trap_badaddr), .et_bit(sr_q[BIT_ET]),
    .base(ebase), .trap_take(take), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .epc_q(epc), .bad_q(badvaddr),
    .err_q(error_mode)
  );

  retire_counter #(.CNT_W(CNT_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .bump(retire && !trap_req), .count(retired)
  );

  assign status       = sr_q;
  assign active_width = wide ? W_WIDE : W_NARROW;
endmodule

// File: rtl/trap_status_unit_checker.sv
module trap_status_unit_checker #(
  parameter int ADDR_W    = 32,
  parameter int CAUSE_W   = 5,
  parameter int CNT_W     = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trap_req,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [ADDR_W-1:0]  trap_pc,
  input logic [ADDR_W-1:0]  trap_badaddr,
  input logic [7:0]         status,
  input logic [6:0]         active_width,
  input logic [ADDR_W-1:0]  ebase,
  input logic [ADDR_W-1:0]  epc,
  input logic [ADDR_W-1:0]  badvaddr,
  input logic               redirect_valid,
  input logic [ADDR_W-1:0]  redirect_pc,
  input logic               error_mode,
  input logic [CNT_W-1:0]   retired
);
  a_r1_vector: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc == $past(ebase) + (ADDR_W'($past(trap_cause)) << 7));
  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);
  a_r2_mode_switch: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> status[0] && !status[2] && status[1] == $past(status[0]));
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> epc == $past(trap_pc) && badvaddr == $past(trap_badaddr));
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_mode |=> error_mode);
  a_r4_disabled_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !status[2]) |=> error_mode && !redirect_valid && $stable(epc));
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);
  a_r7_width: assert property (@(posedge clk) disable iff (!rst_n)
    active_width == 7'd32 || active_width == 7'd64);
  a_r9_no_count_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> retired == $past(retired));
endmodule

bind trap_status_unit trap_status_unit_checker #(
  .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
  .trap_pc(trap_pc), .trap_badaddr(trap_badaddr), .status(status),
  .active_width(active_width), .ebase(ebase), .epc(epc), .badvaddr(badvaddr),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .error_mode(error_mode), .retired(retired)
);

// File: tb/trap_status_unit_bench.sv
module trap_status_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_wr_en = 1'b0;
  logic [7:0] sr_wr_data = '0;
  logic ebase_wr_en = 1'b0;
  logic [31:0] ebase_wr_data = '0;
  logic trap_req = 1'b0;
  logic [4:0] trap_cause = '0;
  logic [31:0] trap_pc = '0;
  logic [31:0] trap_badaddr = '0;
  logic retire = 1'b0;
  logic [7:0] status;
  logic [6:0] active_width;
  logic [31:0] ebase, epc, badvaddr, redirect_pc, retired;
  logic redirect_valid, error_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trap_status_unit u_trap_status_unit (
    .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .ebase_wr_en(ebase_wr_en), .ebase_wr_data(ebase_wr_data),
    .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc),
    .trap_badaddr(trap_badaddr), .retire(retire), .status(status),
    .active_width(active_width), .ebase(ebase), .epc(epc), .badvaddr(badvaddr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .error_mode(error_mode), .retired(retired)
  );

  // {write value, status after write, width after write, cause, status after trap, vector}
  typedef struct packed {
    logic [7:0]  wr;
    logic [7:0]  sr_after_wr;
    logic [6:0]  width;
    logic [4:0]  cause;
    logic [7:0]  sr_after_trap;
    logic [31:0] vec;
  } vec_t;

  localparam vec_t TABLE [5] = '{
    '{8'h05, 8'h15, 7'd64, 5'd3,  8'h13, 32'h1000_0180},
    '{8'h0C, 8'h1C, 7'd64, 5'd0,  8'h19, 32'h1000_0000},
    '{8'hE4, 8'h14, 7'd32, 5'd15, 8'h11, 32'h1000_0780},
    '{8'h07, 8'h17, 7'd64, 5'd7,  8'h13, 32'h1000_0380},
    '{8'h2C, 8'h1C, 7'd64, 5'd19, 8'h19, 32'h1000_0980}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_sr(input logic [7:0] v);
    sr_wr_en = 1'b1; sr_wr_data = v;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R8 status", 32'(status), 32'h11);
    chk("R8 epc", epc, 0);
    chk("R8 badvaddr", badvaddr, 0);
    chk("R8 ebase", ebase, 0);
    chk("R8 retired", retired, 0);
    chk("R8 error", 32'(error_mode), 0);
    chk("R8 redirect_pc", redirect_pc, 0);
    chk("R7 reset width", 32'(active_width), 64);

    ebase_wr_en = 1'b1; ebase_wr_data = 32'h1000_0000;
    @(negedge clk);
    ebase_wr_en = 1'b0;
    chk("R1 ebase write", ebase, 32'h1000_0000);

    for (int i = 0; i < 5; i++) begin
      write_sr(TABLE[i].wr);
      chk("R6 write mask", 32'(status), 32'(TABLE[i].sr_after_wr));
      chk("R7 width", 32'(active_width), 32'(TABLE[i].width));
      trap_req = 1'b1; trap_cause = TABLE[i].cause;
      trap_pc = 32'h2000_0000 + 32'(i * 4); trap_badaddr = 32'hBAD0_0000 + 32'(i);
      @(negedge clk);
      trap_req = 1'b0;
      chk("R1 redirect valid", 32'(redirect_valid), 1);
      chk("R1 vector", redirect_pc, TABLE[i].vec);
      chk("R2 trap status", 32'(status), 32'(TABLE[i].sr_after_trap));
      chk("R3 epc", epc, 32'h2000_0000 + 32'(i * 4));
      chk("R3 badvaddr", badvaddr, 32'hBAD0_0000 + 32'(i));
      @(negedge clk);
      chk("R1 single pulse", 32'(redirect_valid), 0);
    end

    retire = 1'b1;
    repeat (3) @(negedge clk);
    retire = 1'b0;
    chk("R9 count", retired, 3);

    write_sr(8'h05);
    trap_req = 1'b1; trap_cause = 5'd2; retire = 1'b1;
    sr_wr_en = 1'b1; sr_wr_data = 8'h0C;
    trap_pc = 32'h3000_0000; trap_badaddr = 32'h44;
    @(negedge clk);
    trap_req = 1'b0; retire = 1'b0; sr_wr_en = 1'b0;
    chk("R9 no count on trap", retired, 3);
    chk("R10 trap wins status", 32'(status), 32'h13);
    chk("R10 redirect", redirect_pc, 32'h1000_0100);

    write_sr(8'h05);
    trap_req = 1'b1; trap_cause = 5'd25; trap_pc = 32'h5555_0000;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R5 error on bad cause", 32'(error_mode), 1);
    chk("R5 no redirect", 32'(redirect_valid), 0);
    chk("R5 epc kept", epc, 32'h3000_0000);

    do_reset();
    trap_req = 1'b1; trap_cause = 5'd1; trap_pc = 32'h7777_0000;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R4 error on ET clear", 32'(error_mode), 1);
    chk("R4 no redirect", 32'(redirect_valid), 0);
    chk("R4 epc kept", epc, 0);
    chk("R4 status kept", 32'(status), 32'h11);
    write_sr(8'h05);
    trap_req = 1'b1; trap_cause = 5'd1;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R4 ignored in error", 32'(redirect_valid), 0);
    chk("R4 status after ignored trap", 32'(status), 32'h15);
    repeat (3) @(negedge clk);
    chk("R4 sticky", 32'(error_mode), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule